// File: doc/BRIEF.md
# Timer ADC Trigger Router

This block turns the event strobes of a multi-timer PWM unit into ADC trigger pulses. Its inputs are one-cycle strobes from a master timer and six slave timers (A to F), plus ten external events. The strobes are compares, periods, resets and updates. The block has ten trigger outputs, split into two kinds.

Four trigger outputs are of the combining kind. Each one fires when any event enabled in its active mask strobes. Software never writes the active mask directly. A write lands in a shadow copy, and the shadow moves into the active copy only when a chosen timer update strobes. The update is chosen per trigger. This keeps a mask change aligned to a PWM period boundary.

The other six outputs are of the forwarding kind. Each one forwards exactly one event taken from a 32-entry list. All configuration arrives through a simple write port with no read path.

Top module: `trig_route_unit`

## Requirements
- R1: A combining trigger output is high in exactly the cycle in which at least one strobe enabled in its active mask and present in its candidate list is high. Several such strobes in one cycle still give a single high cycle.
- R2: A write to a mask address (0 to 3 for combining triggers 1 to 4) changes only the shadow mask. The trigger behaviour does not change until a transfer happens.
- R3: In the cycle in which a trigger's selected update strobe is high, the active mask loads the shadow value present before that edge. If a mask write falls in the same cycle, the written value becomes active only at a later transfer.
- R4: The update selector (write addresses 4 to 7 for triggers 1 to 4, data bits 2:0) maps code 0 to the master update and codes 1 to 6 to the updates of timers A to F.
- R5: Update-selector code 7 never transfers the shadow mask, whatever update strobes occur.
- R6: Combining triggers 1 and 2 and forwarding triggers 5, 7 and 9 use list X. Bits 3:0 of list X are master compares 1 to 4 and bit 4 is master period. Bits 9:5 are external events 1 to 5. From bit 10 upward, each timer A to F in turn contributes compare 3, compare 4 and period. Timers A, B and F then also contribute their reset, which gives A at 10..13, B at 14..17, C at 18..20, D at 21..23, E at 24..26 and F at 27..30. Bit 31 is never set. Compare c of timer t is input bit tim_cmp[4t+c-1].
- R7: Combining triggers 3 and 4 and forwarding triggers 6, 8 and 10 use list Y. Bits 4:0 of list Y are the master compares 1 to 4 and master period. Bits 9:5 are external events 6 to 10. The timer fields follow in this order:
  - A at 10..12: compare 2, compare 4, period.
  - B at 13..15: compare 2, compare 4, period.
  - C at 16..19: compare 2, compare 4, period, reset.
  - D at 20..23: compare 2, compare 4, period, reset.
  - E at 24..27: compare 2, compare 3, compare 4, reset.
  - F at 28..31: compare 2, compare 3, compare 4, period.
- R8: A write to address 8+j (j = 0 to 5, for triggers 5 to 10) sets the forwarding selection. Data bit 5 is the enable and bits 4:0 are the list index. An enabled forwarding trigger is high exactly when the indexed list bit is high.
- R9: While reset is asserted, and after it, all shadow masks, active masks, update selectors and forwarding selections are cleared. No trigger output fires until it is configured again.
- R10: Writes to addresses 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| mst_cmp | input | 4 | Master compare 1..4 strobes |
| mst_per | input | 1 | Master period strobe |
| mst_upd | input | 1 | Master update strobe |
| tim_cmp | input | 24 | Slave compare strobes, timer t compare c at bit 4t+c-1 |
| tim_per | input | 6 | Slave period strobes, A at bit 0 |
| tim_rst | input | 6 | Slave reset strobes, A at bit 0 |
| tim_upd | input | 6 | Slave update strobes, A at bit 0 |
| ext_evt | input | 10 | External event strobes 1..10 at bits 0..9 |
| or_trig_o | output | 4 | Combining triggers 1..4 |
| sel_trig_o | output | 6 | Forwarding triggers 5..10 |

## Verification
A mask write and the selected update strobe can fall in the same cycle. When they do, the write must reach the shadow while the active copy takes the older shadow value. A directed sequence provokes this by loading the shadow with a master-period mask and transferring it. It then writes a master-compare-1 mask together with a master update. Single strobes then show that only master period fires until another update arrives. The random phase also overlaps writes, updates and event strobes freely, and a bench model of the shadow and active copies judges every cycle.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
  localparam int LIST_W = 32;
  localparam int USRC_W = 3;
  localparam int IDX_W  = $clog2(LIST_W);
  typedef logic [LIST_W-1:0] evt_list_t;
  typedef logic [USRC_W-1:0] usrc_t;
endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/trig_evt_gather.sv
module trig_evt_gather #(
  parameter int N_TIM = 6,
  parameter int N_CMP = 4,
  parameter int N_EXT = 10
) (
  input  logic [N_CMP-1:0]       mst_cmp,
  input  logic                   mst_per,
  input  logic [N_TIM*N_CMP-1:0] tim_cmp,
  input  logic [N_TIM-1:0]       tim_per,
  input  logic [N_TIM-1:0]       tim_rst,
  input  logic [N_EXT-1:0]       ext_evt,
  output trig_route_pkg::evt_list_t list_x,
  output trig_route_pkg::evt_list_t list_y
);
  localparam int TA = 0;
  localparam int TB = 1;
  localparam int TC = 2;
  localparam int TD = 3;
  localparam int TE = 4;
  localparam int TF = 5;

  // compare c (1-based) of timer t
  function automatic logic cmp(input logic [N_TIM*N_CMP-1:0] v, input int t, input int c);
    return v[t*N_CMP + c - 1];
  endfunction

  always_comb begin
    list_x        = '0;
    list_x[3:0]   = mst_cmp[3:0];
    list_x[4]     = mst_per;
    list_x[9:5]   = ext_evt[4:0];
    list_x[12:10] = {tim_per[TA], cmp(tim_cmp, TA, 4), cmp(tim_cmp, TA, 3)};
    list_x[13]    = tim_rst[TA];
    list_x[16:14] = {tim_per[TB], cmp(tim_cmp, TB, 4), cmp(tim_cmp, TB, 3)};
    list_x[17]    = tim_rst[TB];
    list_x[20:18] = {tim_per[TC], cmp(tim_cmp, TC, 4), cmp(tim_cmp, TC, 3)};
    list_x[23:21] = {tim_per[TD], cmp(tim_cmp, TD, 4), cmp(tim_cmp, TD, 3)};
    list_x[26:24] = {tim_per[TE], cmp(tim_cmp, TE, 4), cmp(tim_cmp, TE, 3)};
    list_x[29:27] = {tim_per[TF], cmp(tim_cmp, TF, 4), cmp(tim_cmp, TF, 3)};
    list_x[30]    = tim_rst[TF];
  end

  always_comb begin
    list_y        = '0;
    list_y[3:0]   = mst_cmp[3:0];
    list_y[4]     = mst_per;
    list_y[9:5]   = ext_evt[9:5];
    list_y[12:10] = {tim_per[TA], cmp(tim_cmp, TA, 4), cmp(tim_cmp, TA, 2)};
    list_y[15:13] = {tim_per[TB], cmp(tim_cmp, TB, 4), cmp(tim_cmp, TB, 2)};
    list_y[19:16] = {tim_rst[TC], tim_per[TC], cmp(tim_cmp, TC, 4), cmp(tim_cmp, TC, 2)};
    list_y[23:20] = {tim_rst[TD], tim_per[TD], cmp(tim_cmp, TD, 4), cmp(tim_cmp, TD, 2)};
    list_y[27:24] = {tim_rst[TE], cmp(tim_cmp, TE, 4), cmp(tim_cmp, TE, 3), cmp(tim_cmp, TE, 2)};
    list_y[31:28] = {tim_per[TF], cmp(tim_cmp, TF, 4), cmp(tim_cmp, TF, 3), cmp(tim_cmp, TF, 2)};
  end
endmodule

// File: rtl/trig_or_chan.sv
module trig_or_chan #(
  parameter int LIST_W = 32,
  parameter int USRC_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mask_we,
  input  logic [LIST_W-1:0]          mask_wdata,
  input  logic [USRC_W-1:0]          usrc,
  input  logic [(1<<USRC_W)-1:0]     upd_vec,
  input  logic [LIST_W-1:0]          cand,
  output logic                       trig_o,
  output logic                       xfer_o,
  output logic [LIST_W-1:0]          shd_o,
  output logic [LIST_W-1:0]          act_o
);
  localparam logic [USRC_W-1:0] USRC_RSVD = '1;

  logic [LIST_W-1:0] shd_q, shd_d;
  logic [LIST_W-1:0] act_q, act_d;
  logic              shd_ce, act_ce;

  always_comb begin
    act_ce = (usrc != USRC_RSVD) && upd_vec[usrc];
    shd_ce = mask_we;
    shd_d  = mask_wdata;
    act_d  = shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (shd_ce) shd_q <= shd_d;
      if (act_ce) act_q <= act_d;
    end
  end

  assign trig_o = |(act_q & cand);
  assign xfer_o = act_ce;
  assign shd_o  = shd_q;
  assign act_o  = act_q;
endmodule

// File: rtl/trig_sel_chan.sv
module trig_sel_chan #(
  parameter int LIST_W = 32,
  parameter int IDX_W  = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [IDX_W:0]    sel_wdata,
  input  logic [LIST_W-1:0] cand,
  output logic              trig_o,
  output logic              en_o
);
  logic             en_q, en_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    en_d  = sel_wdata[IDX_W];
    idx_d = sel_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else if (sel_we) begin
      en_q  <= en_d;
      idx_q <= idx_d;
    end
  end

  assign trig_o = en_q & cand[idx_q];
  assign en_o   = en_q;
endmodule

// File: rtl/trig_route_unit.sv
module trig_route_unit #(
  parameter int N_TIM  = 6,
  parameter int N_CMP  = 4,
  parameter int N_EXT  = 10,
  parameter int N_OR   = 4,
  parameter int N_SEL  = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [N_CMP-1:0]       mst_cmp,
  input  logic                   mst_per,
  input  logic                   mst_upd,
  input  logic [N_TIM*N_CMP-1:0] tim_cmp,
  input  logic [N_TIM-1:0]       tim_per,
  input  logic [N_TIM-1:0]       tim_rst,
  input  logic [N_TIM-1:0]       tim_upd,
  input  logic [N_EXT-1:0]       ext_evt,
  output logic [N_OR-1:0]        or_trig_o,
  output logic [N_SEL-1:0]       sel_trig_o
);
  import trig_route_pkg::*;

  localparam int N_UPD     = 1 << USRC_W;
  localparam int USRC_BASE = N_OR;
  localparam int SEL_BASE  = 2 * N_OR;

  logic                             rst_sync_n;
  evt_list_t                        list_x, list_y;
  logic [N_UPD-1:0]                 upd_vec;
  logic [N_OR-1:0]                  mask_we, usrc_we, xfer_vec;
  logic [N_SEL-1:0]                 sel_we, sel_en;
  logic [N_OR-1:0][USRC_W-1:0]      usrc_q, usrc_d;
  logic [N_OR-1:0][LIST_W-1:0]      shd_mask, act_mask;

  trig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  trig_evt_gather #(.N_TIM(N_TIM), .N_CMP(N_CMP), .N_EXT(N_EXT)) u_gather (
    .mst_cmp (mst_cmp),
    .mst_per (mst_per),
    .tim_cmp (tim_cmp),
    .tim_per (tim_per),
    .tim_rst (tim_rst),
    .ext_evt (ext_evt),
    .list_x  (list_x),
    .list_y  (list_y)
  );

  assign upd_vec = N_UPD'({tim_upd, mst_upd});

  // write decode
  always_comb begin
    for (int k = 0; k < N_OR; k++) begin
      mask_we[k] = wr_en && (wr_addr == ADDR_W'(k));
      usrc_we[k] = wr_en && (wr_addr == ADDR_W'(USRC_BASE + k));
    end
    for (int j = 0; j < N_SEL; j++) begin
      sel_we[j] = wr_en && (wr_addr == ADDR_W'(SEL_BASE + j));
    end
  end

  // update-source selectors: next state
  always_comb begin
    for (int k = 0; k < N_OR; k++) begin
      usrc_d[k] = wr_data[USRC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      usrc_q <= '0;
    end else begin
      for (int k = 0; k < N_OR; k++) begin
        if (usrc_we[k]) usrc_q[k] <= usrc_d[k];
      end
    end
  end

  for (genvar k = 0; k < N_OR; k++) begin : g_or
    evt_list_t cand;
    if (k < N_OR / 2) begin : g_lx
      assign cand = list_x;
    end else begin : g_ly
      assign cand = list_y;
    end
    trig_or_chan #(.LIST_W(LIST_W), .USRC_W(USRC_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .mask_we    (mask_we[k]),
      .mask_wdata (wr_data[LIST_W-1:0]),
      .usrc       (usrc_q[k]),
      .upd_vec    (upd_vec),
      .cand       (cand),
      .trig_o     (or_trig_o[k]),
      .xfer_o     (xfer_vec[k]),
      .shd_o      (shd_mask[k]),
      .act_o      (act_mask[k])
    );
  end

  for (genvar j = 0; j < N_SEL; j++) begin : g_sel
    evt_list_t cand;
    if ((j % 2) == 0) begin : g_lx
      assign cand = list_x;
    end else begin : g_ly
      assign cand = list_y;
    end
    trig_sel_chan #(.LIST_W(LIST_W), .IDX_W(IDX_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sel_we    (sel_we[j]),
      .sel_wdata (wr_data[IDX_W:0]),
      .cand      (cand),
      .trig_o    (sel_trig_o[j]),
      .en_o      (sel_en[j])
    );
  end
endmodule

// File: rtl/trig_route_chk.sv
module trig_route_chk #(
  parameter int N_OR   = 4,
  parameter int N_SEL  = 6,
  parameter int LIST_W = 32,
  parameter int USRC_W = 3
) (
  input logic                        clk,
  input logic                        rst_in_n,
  input logic                        rst_n,
  input logic [N_OR-1:0]             xfer,
  input logic [N_OR-1:0][USRC_W-1:0] usrc,
  input logic [N_OR-1:0][LIST_W-1:0] act,
  input logic [N_OR-1:0][LIST_W-1:0] shd,
  input logic [N_OR-1:0]             or_trig,
  input logic [N_SEL-1:0]            sel_trig,
  input logic [N_SEL-1:0]            sel_en
);
  for (genvar k = 0; k < N_OR; k++) begin : g_or
    // R2: active copy holds without a transfer
    a_r2_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer[k] |=> $stable(act[k]));
    // R3: transfer loads the pre-edge shadow
    a_r3_load_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      xfer[k] |=> (act[k] == $past(shd[k])));
    // R5: reserved selector never transfers
    a_r5_reserved_no_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (usrc[k] == '1) |-> !xfer[k]);
    // R1: a pulse needs a non-empty active mask
    a_r1_pulse_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      or_trig[k] |-> (act[k] != '0));
  end

  for (genvar j = 0; j < N_SEL; j++) begin : g_sel
    // R8: forwarding needs the enable
    a_r8_fwd_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sel_trig[j] |-> sel_en[j]);
  end

  // R9: outputs quiet while reset is held
  a_r9_quiet_in_reset: assert property (@(posedge clk)
    !rst_in_n |-> ((or_trig == '0) && (sel_trig == '0)));
endmodule

bind trig_route_unit trig_route_chk #(
  .N_OR   (N_OR),
  .N_SEL  (N_SEL),
  .LIST_W (trig_route_pkg::LIST_W),
  .USRC_W (trig_route_pkg::USRC_W)
) u_chk (
  .clk      (clk),
  .rst_in_n (rst_n),
  .rst_n    (rst_sync_n),
  .xfer     (xfer_vec),
  .usrc     (usrc_q),
  .act      (act_mask),
  .shd      (shd_mask),
  .or_trig  (or_trig_o),
  .sel_trig (sel_trig_o),
  .sel_en   (sel_en)
);

// File: tb/tb_trig_route_unit.sv
module tb_trig_route_unit;
  localparam int CLK_P = 10;
  localparam int NEV   = 51;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [NEV-1:0] ev;
  logic [6:0]  upd;
  logic [3:0]  or_trig_o;
  logic [5:0]  sel_trig_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  // bench model state
  logic [31:0] m_shd [4];
  logic [31:0] m_act [4];
  logic [2:0]  m_usrc [4];
  logic        m_en [6];
  logic [4:0]  m_idx [6];
  int          skip = 0;

  always #(CLK_P/2) clk = ~clk;

  trig_route_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mst_cmp    (ev[3:0]),
    .mst_per    (ev[4]),
    .mst_upd    (upd[0]),
    .tim_cmp    (ev[28:5]),
    .tim_per    (ev[34:29]),
    .tim_rst    (ev[40:35]),
    .tim_upd    (upd[6:1]),
    .ext_evt    (ev[50:41]),
    .or_trig_o  (or_trig_o),
    .sel_trig_o (sel_trig_o)
  );

  function automatic logic tc(input logic [NEV-1:0] e, input int t, input int c);
    return e[5 + t*4 + c - 1];
  endfunction

  // list X from R6
  function automatic logic [31:0] lx(input logic [NEV-1:0] e);
    logic [31:0] v = '0;
    int p = 10;
    for (int i = 0; i < 5; i++) v[i] = e[i];
    for (int i = 0; i < 5; i++) v[5+i] = e[41+i];
    for (int t = 0; t < 6; t++) begin
      v[p] = tc(e, t, 3); p++;
      v[p] = tc(e, t, 4); p++;
      v[p] = e[29+t];     p++;
      if (t == 0 || t == 1 || t == 5) begin v[p] = e[35+t]; p++; end
    end
    return v;
  endfunction

  // list Y from R7
  function automatic logic [31:0] ly(input logic [NEV-1:0] e);
    logic [31:0] v = '0;
    int p = 10;
    for (int i = 0; i < 5; i++) v[i] = e[i];
    for (int i = 0; i < 5; i++) v[5+i] = e[46+i];
    for (int t = 0; t < 6; t++) begin
      v[p] = tc(e, t, 2); p++;
      if (t >= 4) begin v[p] = tc(e, t, 3); p++; end
      v[p] = tc(e, t, 4); p++;
      if (t != 4) begin v[p] = e[29+t]; p++; end
      if (t >= 2 && t <= 4) begin v[p] = e[35+t]; p++; end
    end
    return v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 4; k++) begin m_shd[k] = '0; m_act[k] = '0; m_usrc[k] = '0; end
    for (int j = 0; j < 6; j++) begin m_en[j] = 1'b0; m_idx[j] = '0; end
  endtask

  task automatic check_outputs();
    logic [3:0] eo;
    logic [5:0] es;
    logic [31:0] x, y;
    x = lx(ev);
    y = ly(ev);
    for (int k = 0; k < 4; k++) eo[k] = |(m_act[k] & ((k < 2) ? x : y));
    for (int j = 0; j < 6; j++) es[j] = m_en[j] & (((j % 2) == 0) ? x[m_idx[j]] : y[m_idx[j]]);
    if (!rst_n) begin eo = '0; es = '0; end
    checks++;
    if (or_trig_o !== eo) begin
      fails++;
      $display("FAIL %s or_trig got %b exp %b", tag, or_trig_o, eo);
    end
    checks++;
    if (sel_trig_o !== es) begin
      fails++;
      $display("FAIL %s sel_trig got %b exp %b", tag, sel_trig_o, es);
    end
  endtask

  task automatic model_update();
    logic [7:0] uv;
    if (!rst_n) begin
      model_clear();
      return;
    end
    if (skip > 0) begin
      skip--;
      return;
    end
    uv = {1'b0, upd};
    for (int k = 0; k < 4; k++)
      if (m_usrc[k] != 3'd7 && uv[m_usrc[k]]) m_act[k] = m_shd[k];
    if (wr_en) begin
      if (wr_addr < 4)       m_shd[wr_addr[1:0]] = wr_data;
      else if (wr_addr < 8)  m_usrc[wr_addr - 4] = wr_data[2:0];
      else if (wr_addr < 14) begin
        m_en[wr_addr - 8]  = wr_data[5];
        m_idx[wr_addr - 8] = wr_data[4:0];
      end
    end
  endtask

  task automatic tick();
    #(CLK_P/4);
    check_outputs();
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_in();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; ev = '0; upd = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    idle_in();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tag = "R9";
    for (int i = 0; i < 4; i++) begin
      idle_in();
      for (int b = 0; b < NEV; b++) ev[b] = ($urandom % 3) == 0;
      upd = 7'($urandom);
      tick();
    end
    idle_in();
    rst_n = 1'b1;
    skip = 2;
    for (int i = 0; i < 3; i++) tick();
    // all events after reset: nothing configured, nothing fires
    ev = '1; upd = '1;
    tick();
    idle_in();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_in();
    rst_n = 1'b0;
    @(negedge clk);
    model_clear();
    do_reset();

    // R10: unmapped addresses change nothing
    tag = "R10";
    wr(4'd14, '1);
    wr(4'd15, '1);
    upd = '1; tick();
    idle_in(); ev = '1; tick();
    idle_in();

    // R6, R7, R8: sweep each list position against every single strobe
    for (int b = 0; b < 32; b++) begin
      tag = "R8";
      wr(4'd0, 32'd1 << b);
      wr(4'd2, 32'd1 << b);
      wr(4'd8, 32'h20 | 32'(b));
      wr(4'd9, 32'h20 | 32'(b));
      upd = 7'b1; tick();
      idle_in();
      for (int i = 0; i < NEV; i++) begin
        tag = ((i % 2) == 0) ? "R6" : "R7";
        ev = '0; ev[i] = 1'b1;
        tick();
      end
      idle_in();
    end

    // R1: random mix of writes, updates and strobes
    tag = "R1";
    for (int c = 0; c < 4000; c++) begin
      idle_in();
      for (int b = 0; b < NEV; b++) ev[b] = ($urandom % 8) == 0;
      for (int u = 0; u < 7; u++) upd[u] = ($urandom % 6) == 0;
      if (($urandom % 4) == 0) begin
        wr_en = 1'b1; wr_addr = 4'($urandom); wr_data = $urandom;
      end
      tick();
    end
    idle_in();

    // R9: reset from a configured state
    do_reset();

    // R2: shadow write alone has no effect
    tag = "R2";
    wr(4'd1, '1);
    ev = '1; tick();
    idle_in();

    // R3: write and selected update in the same cycle
    tag = "R3";
    wr(4'd0, 32'h10);
    upd = 7'b1; tick();
    idle_in();
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h1; upd = 7'b1;
    tick();
    idle_in(); ev[0] = 1'b1; tick();
    idle_in(); ev[4] = 1'b1; tick();
    idle_in(); upd = 7'b1; tick();
    idle_in(); ev[0] = 1'b1; tick();
    idle_in(); ev[4] = 1'b1; tick();
    idle_in();

    // R4, R5: every selector code against every update strobe
    for (int s = 0; s < 8; s++) begin
      tag = (s == 7) ? "R5" : "R4";
      wr(4'd5, 32'(s));
      for (int u = 0; u < 7; u++) begin
        wr(4'd1, (u % 2 == 0) ? 32'hFFFF_FFFF : 32'h0);
        upd = 7'b1 << u; tick();
        idle_in(); ev = '1; tick();
        idle_in();
      end
    end

    summary();
  end
endmodule